// File: doc/BRIEF.md
# Serial Character Transmitter with Clear-to-Send Pacing

This block turns a stream of bytes into an asynchronous serial line. Each byte is sent as a ten-bit character: a low start bit, eight data bits with the least significant bit first, and a high stop bit. The line advances by one bit on each pulse of the external `baud_tick` strobe. Between characters the line rests high (mark).

When `flow_en` is high, the active-low clear-to-send input `cts_n` paces the transmitter, but only at character boundaries. A character that has started is always completed. The clear-to-send level is sampled at the midpoint of every character. If it is negated there, the transmitter halts once that character ends. If it is negated only after the midpoint, the next pending character still goes out in full, and its own midpoint sample then halts the line. While halted, the block sends whole idle characters: ten bit times of mark. At the end of each idle character it looks at clear-to-send again. A reassertion therefore resumes with the pending byte at the next idle-character boundary. No byte is dropped or repeated, and no error is raised. When `flow_en` is low, `cts_n` has no effect.

The byte input is a valid/ready stream. `in_ready` is high only in a cycle where `baud_tick` is high, the transmitter is at a character boundary, and sending is allowed. A byte transfers in a cycle where `in_valid` and `in_ready` are both high. A source with a byte to send holds `in_valid` high and keeps `in_data` stable until that transfer happens. Back-pressure lasts for the whole of a character in flight and for every held idle character.

Top module: `tx_flow_serializer`

## Requirements
- R1: An accepted byte appears on `txd` as a start bit 0, then data bits 0 through 7, then a stop bit 1. Each bit lasts exactly one baud-tick interval, and `txd` changes only at a clock edge where `baud_tick` is high.
- R2: `in_ready` is high only in a cycle with `baud_tick` high. A byte is taken when `in_valid` and `in_ready` are both high, and `txd` falls to the start bit in the next cycle.
- R3: A byte that is pending when a character ends starts at that same boundary, so consecutive characters begin exactly ten ticks apart.
- R4: With `flow_en` low, `cts_n` has no effect: bytes go out whatever its level, and `paused` never rises.
- R5: With `flow_en` high, if `cts_n` is high at the midpoint sample of a character (after its fifth bit), that character is completed and no further byte starts.
- R6: With `flow_en` high, if `cts_n` rises only after the midpoint sample of a character, the next pending byte is still sent in full, and the transmitter halts after it.
- R7: While halted, `paused` is high, `txd` stays at 1, and no byte is accepted while `cts_n` remains high. The hold lasts a whole number of ten-tick idle characters.
- R8: After `cts_n` returns low, the pending byte is sent intact at the next idle-character boundary, and `paused` falls. Every byte is sent exactly once.
- R9: After reset, `txd` is 1, `paused` is 0 and `in_ready` is 0 outside tick cycles. `cts_n` passes through two flip-flops before it is used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle strobe marking each bit boundary |
| in_valid | input | 1 | Byte offered on `in_data` |
| in_data | input | 8 | Byte to transmit |
| in_ready | output | 1 | Byte accepted this cycle if `in_valid` is high |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| flow_en | input | 1 | Enables pacing by `cts_n` |
| txd | output | 1 | Serial line, idle high |
| paused | output | 1 | High while held off by clear-to-send |

## Verification
A wrong bit counter or shift register shows up as a bad byte, a missing stop bit or a wrong character spacing. The decoder on `txd` catches it within the same ten-tick character. A wrong midpoint sample or boundary decision shows up as one character too many or too few before the hold. It also shows up as `paused` rising in the wrong idle window. All of these appear within two characters of the clear-to-send change. A stuck hold state shows up as a byte that never arrives after reassertion, which the bench reports within three idle characters.

// File: rtl/tx_fc_pkg.sv
package tx_fc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_HOLD = 2'd2
  } tx_state_e;
endpackage

// File: rtl/tx_fc_sync.sv
module tx_fc_sync #(
  parameter int STAGES = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];

  // R9: the synchronised level always equals the input from STAGES edges earlier
  generate
    if (STAGES == 2) begin : g_chk
      assert_sync_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n, 2) |-> (q == $past(d, 2)));
    end
  endgenerate
endmodule

// File: rtl/tx_fc_gate.sv
module tx_fc_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic flow_en,
  input  logic cts_neg,   // synchronised, 1 = not clear to send
  input  logic at_mid,    // tick that ends the fifth bit of a data character
  input  logic in_send,   // a data character is on the line
  output logic go         // sending may start at the current boundary
);
  logic mid_ok_q;

  // midpoint sample of the character in flight
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mid_ok_q <= 1'b1;
    else if (at_mid) mid_ok_q <= !cts_neg;
  end

  // after a data character the midpoint sample rules; otherwise the live level
  always_comb begin
    if (!flow_en)     go = 1'b1;
    else if (in_send) go = mid_ok_q;
    else              go = !cts_neg;
  end

  // R6: a clear midpoint sample keeps the end-of-character boundary open
  assert_late_negation_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (at_mid && !cts_neg) |=> (in_send && go));
endmodule

// File: rtl/tx_fc_frame.sv
module tx_fc_frame
  import tx_fc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              go,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              txd,
  output logic              hold,
  output logic              in_send,
  output logic              at_mid
);
  localparam int FRAME_LEN = DATA_W + 2;
  localparam int MID       = FRAME_LEN / 2;
  localparam int CW        = $clog2(FRAME_LEN);
  localparam logic [CW-1:0] LAST_IDX = CW'(FRAME_LEN - 1);
  localparam logic [CW-1:0] MID_IDX  = CW'(MID - 1);

  tx_state_e            st_q;
  logic [CW-1:0]        cnt_q;
  logic [FRAME_LEN-1:0] frame_q;
  logic                 boundary;
  logic                 take;

  assign boundary = (st_q == ST_IDLE) || (cnt_q == LAST_IDX);
  assign in_ready = tick && boundary && go;
  assign take     = in_ready && in_valid;
  assign in_send  = (st_q == ST_SEND);
  assign hold     = (st_q == ST_HOLD);
  assign at_mid   = tick && in_send && (cnt_q == MID_IDX);
  assign txd      = frame_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      frame_q <= '1;
    end else if (tick) begin
      if (boundary) begin
        cnt_q <= '0;
        if (take) begin
          st_q    <= ST_SEND;
          frame_q <= {1'b1, in_data, 1'b0};
        end else begin
          st_q    <= go ? ST_IDLE : ST_HOLD;
          frame_q <= '1;
        end
      end else begin
        cnt_q   <= cnt_q + 1'b1;
        frame_q <= {1'b1, frame_q[FRAME_LEN-1:1]};
      end
    end
  end

  assert_start_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !txd);

  assert_ready_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> tick);

  assert_line_steady_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(txd));

  assert_hold_mark_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> txd);

  assert_count_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_IDX);

  // R5: a character started while clear-to-send is refused never begins
  assert_no_start_refused_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && boundary && !go) |=> hold);
endmodule

// File: rtl/tx_flow_serializer.sv
module tx_flow_serializer #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              cts_n,
  input  logic              flow_en,
  output logic              txd,
  output logic              paused
);
  logic cts_neg;
  logic go;
  logic at_mid;
  logic in_send;

  tx_fc_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (cts_n),
    .q     (cts_neg)
  );

  tx_fc_gate u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .flow_en (flow_en),
    .cts_neg (cts_neg),
    .at_mid  (at_mid),
    .in_send (in_send),
    .go      (go)
  );

  tx_fc_frame #(.DATA_W(DATA_W)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (baud_tick),
    .go       (go),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_ready (in_ready),
    .txd      (txd),
    .hold     (paused),
    .in_send  (in_send),
    .at_mid   (at_mid)
  );

  assert_flow_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow_en && !paused) |=> !paused);
endmodule

// File: tb/tx_flow_serializer_test.sv
`timescale 1ns/1ps
module tx_flow_serializer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready;
  logic       cts_n = 1'b0;
  logic       flow_en = 1'b0;
  logic       txd;
  logic       paused;

  int checks = 0;
  int errors = 0;

  // line decoder state
  int        tick_no = 0;
  int        rx_cnt = 0;
  int        acc_cnt = 0;
  int        frame_err = 0;
  logic [7:0] rx_data [0:63];
  int        rx_start [0:63];
  bit        in_frame = 1'b0;
  int        bitn = 0;
  int        cur_start = 0;
  logic [7:0] sh = 8'h00;
  int        viol_tick = 0;
  int        viol_pause = 0;
  int        viol_mark = 0;
  int        paused_seen_off = 0;

  // {cts_n during send, data}; sent with pacing disabled
  localparam logic [8:0] VECS [6] = '{9'h0A5, 9'h13C, 9'h000, 9'h1FF, 9'h081, 9'h17E};

  tx_flow_serializer uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .cts_n     (cts_n),
    .flow_en   (flow_en),
    .txd       (txd),
    .paused    (paused)
  );

  always #5 clk = ~clk;

  initial begin
    wait (rst_n);
    forever begin
      repeat (3) @(posedge clk);
      #1 baud_tick = 1'b1;
      @(posedge clk);
      #1 baud_tick = 1'b0;
    end
  end

  // monitor: each tick cycle shows the bit that ends at that tick
  always @(negedge clk) begin
    if (rst_n) begin
      if (in_ready && !baud_tick) viol_tick++;
      if (paused && in_ready && cts_n && flow_en) viol_pause++;
      if (paused && !txd) viol_mark++;
      if (paused && !flow_en) paused_seen_off++;
      if (in_valid && in_ready) acc_cnt++;
      if (baud_tick) begin
        tick_no++;
        if (!in_frame) begin
          if (!txd) begin
            in_frame = 1'b1;
            bitn = 0;
            cur_start = tick_no;
          end
        end else begin
          bitn++;
          if (bitn <= 8) sh[bitn-1] = txd;
          else begin
            if (!txd) frame_err++;
            rx_data[rx_cnt] = sh;
            rx_start[rx_cnt] = cur_start;
            rx_cnt++;
            in_frame = 1'b0;
          end
        end
      end
    end
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(posedge clk);
    #1 in_valid = 1'b1;
    in_data = b;
    do @(negedge clk); while (!in_ready);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic wait_ticks(input int n);
    int t = 0;
    while (t < n) begin
      @(negedge clk);
      if (baud_tick) t++;
    end
  endtask

  task automatic wait_rx(input int target, input int lim);
    int t = 0;
    while (rx_cnt < target && t < lim) begin
      @(negedge clk);
      if (baud_tick) t++;
    end
    wait_ticks(1);
  endtask

  initial begin
    int base;
    int accb;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    chk(txd == 1'b1, "R9", "txd in reset", txd, 1);
    chk(paused == 1'b0, "R9", "paused in reset", paused, 0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b0, "R9", "in_ready off tick", in_ready, 0);
    wait_ticks(3);

    // R1/R4: table walk, pacing off, cts level varies
    for (int i = 0; i < 6; i++) begin
      flow_en = 1'b0;
      cts_n = VECS[i][8];
      base = rx_cnt;
      send(VECS[i][7:0]);
      wait_rx(base + 1, 30);
      chk(rx_cnt == base + 1, "R4", "byte count with pacing off", rx_cnt, base + 1);
      chk(rx_data[base] == VECS[i][7:0], "R1", "decoded byte", rx_data[base], VECS[i][7:0]);
    end
    chk(frame_err == 0, "R1", "stop bit errors", frame_err, 0);
    cts_n = 1'b0;

    // R3: back-to-back spacing
    base = rx_cnt;
    send(8'h3C);
    send(8'hC3);
    wait_rx(base + 2, 40);
    chk(rx_cnt == base + 2, "R3", "pair received", rx_cnt, base + 2);
    chk(rx_start[base+1] - rx_start[base] == 10, "R3", "start spacing",
        rx_start[base+1] - rx_start[base], 10);

    // R7/R8: held from idle
    flow_en = 1'b1;
    cts_n = 1'b1;
    wait_ticks(12);
    base = rx_cnt;
    accb = acc_cnt;
    fork
      send(8'h5A);
      begin
        wait_ticks(30);
        chk(acc_cnt == accb, "R7", "no accept while held", acc_cnt, accb);
        chk(paused == 1'b1, "R7", "paused while held", paused, 1);
        chk(txd == 1'b1, "R7", "line mark while held", txd, 1);
        cts_n = 1'b0;
      end
    join
    wait_rx(base + 1, 40);
    chk(rx_cnt == base + 1 && rx_data[base] == 8'h5A, "R8", "byte after release",
        rx_data[base], 8'h5A);
    chk(paused == 1'b0, "R8", "paused cleared", paused, 0);

    // R5: negation before the midpoint halts after the current character
    base = rx_cnt;
    accb = acc_cnt;
    fork
      begin send(8'h11); send(8'h22); end
      begin
        wait (acc_cnt == accb + 1);
        wait_ticks(2);
        cts_n = 1'b1;
        wait_ticks(30);
        chk(rx_cnt == base + 1, "R5", "only current char sent", rx_cnt, base + 1);
        chk(rx_data[base] == 8'h11, "R5", "current char intact", rx_data[base], 8'h11);
        chk(paused == 1'b1, "R5", "paused after char", paused, 1);
        cts_n = 1'b0;
      end
    join
    wait_rx(base + 2, 40);
    chk(rx_cnt == base + 2 && rx_data[base+1] == 8'h22, "R8", "pending byte resumes",
        rx_data[base+1], 8'h22);

    // R6: negation after the midpoint lets one more character out
    base = rx_cnt;
    accb = acc_cnt;
    fork
      begin send(8'hA1); send(8'hB2); send(8'hC3); end
      begin
        wait (acc_cnt == accb + 1);
        wait_ticks(7);
        cts_n = 1'b1;
        wait_ticks(30);
        chk(rx_cnt == base + 2, "R6", "one extra char", rx_cnt, base + 2);
        chk(rx_data[base+1] == 8'hB2, "R6", "extra char intact", rx_data[base+1], 8'hB2);
        chk(rx_start[base+1] - rx_start[base] == 10, "R6", "extra char spacing",
            rx_start[base+1] - rx_start[base], 10);
        chk(paused == 1'b1, "R6", "paused after extra", paused, 1);
        cts_n = 1'b0;
      end
    join
    wait_rx(base + 3, 40);
    chk(rx_cnt == base + 3 && rx_data[base+2] == 8'hC3, "R8", "third byte resumes",
        rx_data[base+2], 8'hC3);

    flow_en = 1'b0;
    wait_ticks(3);
    chk(viol_tick == 0, "R2", "ready outside tick", viol_tick, 0);
    chk(viol_pause == 0, "R7", "ready while held", viol_pause, 0);
    chk(viol_mark == 0, "R7", "space while held", viol_mark, 0);
    chk(frame_err == 0, "R1", "stop bit errors total", frame_err, 0);
    chk(acc_cnt == rx_cnt, "R8", "accepted equals sent", rx_cnt, acc_cnt);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule